// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles control flow for one instruction of an integer core per cycle. A decoded request brings a condition or jump kind, two source operands up to 128 bits wide (each given as a low and a high 64-bit half), the current program counter, a sign-extended immediate, the instruction length and the state of compressed-instruction support. One cycle later the block reports whether control is redirected, the address to fetch next, the return address for jumps with its write enable, and an instruction-address-misaligned flag.

The wide compare is formed from the halves. Equality ORs the XOR of each half pair. Signed order takes the sign of the 128-bit difference and corrects it with an overflow term. Unsigned order chains the borrow of the low-half subtraction into the high half. When the second source names the zero register, the compare is reduced to a test on the first operand alone. Target checks depend on compressed-instruction support: without it, a redirect to an address that is not a multiple of four is refused and flagged instead.

Top module: `bru_resolve`

## Requirements
- R1: With `op` 0 the request is taken when the two 128-bit operands {hi,lo} are equal. With `op` 1 it is taken when they differ. A difference in either half counts.
- R2: With `op` 2 the request is taken when operand 1 < operand 2 as signed 128-bit values. With `op` 3 it is taken when operand 1 >= operand 2, also signed.
- R3: With `op` 4 the request is taken when operand 1 < operand 2 as unsigned 128-bit values. With `op` 5 it is taken when operand 1 >= operand 2, also unsigned. A borrow out of the low half decides the order when the high halves are equal.
- R4: When `src2_is_x0` is 1, the `src2_lo` and `src2_hi` inputs are ignored and the second operand is zero for all six conditions.
- R5: `next_pc` is the target when the condition holds. Otherwise it is `pc` plus the instruction length, which is 2 when `short_insn` is 1 and 4 when it is 0.
- R6: For a conditional branch (`op` 0 to 5) whose condition holds, with `rvc_en` at 0, a target with bits [1:0] not zero sets `misaligned`, clears `taken`, and still reports the target on `next_pc`. With `rvc_en` at 1 no such check is made.
- R7: `op` 7 is an indirect jump to (`src1_lo` + `imm`) with bit 0 cleared. With `rvc_en` at 0, bit 1 of that target being set raises `misaligned` and clears `taken`.
- R8: `op` 6 is a direct jump. It is always requested to `pc` + `imm`, under the same alignment rule as R6.
- R9: For `op` 6 and 7, `link_val` is `pc` plus the instruction length. `link_we` is 1 only when `rd` is not 0 and the jump is not misaligned. Conditional branches never assert `link_we`.
- R10: The results appear on the clock edge after the edge that samples `in_valid`, with `out_valid` set. In a cycle without a request, `out_valid`, `taken`, `link_we` and `misaligned` are 0. A synchronous reset clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Condition or jump kind (encoding in R1 to R3, R7, R8) |
| src1_lo | input | 64 | Operand 1, low half |
| src1_hi | input | 64 | Operand 1, high half |
| src2_lo | input | 64 | Operand 2, low half |
| src2_hi | input | 64 | Operand 2, high half |
| src2_is_x0 | input | 1 | Second source is the zero register |
| pc | input | 64 | Address of the instruction |
| imm | input | 64 | Sign-extended offset |
| short_insn | input | 1 | Instruction is 2 bytes long |
| rvc_en | input | 1 | Compressed instructions enabled |
| rd | input | 5 | Link destination register index |
| out_valid | output | 1 | Result present |
| taken | output | 1 | Control is redirected to next_pc |
| next_pc | output | 64 | Next fetch address, or the faulting target |
| link_we | output | 1 | Write link_val to link_rd |
| link_rd | output | 5 | Link destination register index |
| link_val | output | 64 | Return address |
| misaligned | output | 1 | Instruction-address-misaligned exception |

## Verification
The compare is tested with operands that agree in one half and differ in the other. This shows that both halves feed equality and that a low-half borrow settles unsigned order. Extreme signed pairs (most negative against most positive, minus one against one) separate the overflow-corrected signed result from the unsigned one. Zero-register requests carry non-zero garbage on the second source to show it has no effect. Targets are taken with the low two bits both clear and set, with compressed support on and off, to separate the branch rule from the indirect-jump rule, along with link writes to register 0 and to other registers. Long runs of random operands are compared with a behavioural model every cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    BR_EQ   = 3'd0,
    BR_NE   = 3'd1,
    BR_LT   = 3'd2,
    BR_GE   = 3'd3,
    BR_LTU  = 3'd4,
    BR_GEU  = 3'd5,
    JMP_DIR = 3'd6,
    JMP_IND = 3'd7
  } bru_op_e;
endpackage

// File: rtl/bru_cmp.sv
// Wide compare assembled from two half-width words.
module bru_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_lo,
  input  logic [W-1:0] a_hi,
  input  logic [W-1:0] b_lo,
  input  logic [W-1:0] b_hi,
  input  logic         b_zero,
  output logic         eq,
  output logic         lt,
  output logic         ltu
);
  logic [W:0] diff_lo;
  logic [W:0] diff_hi;
  logic       ovf;
  logic       eq_full, lt_full, ltu_full;

  always_comb begin
    // low half: bit W is the borrow passed upward
    diff_lo  = {1'b0, a_lo} - {1'b0, b_lo};
    diff_hi  = {1'b0, a_hi} - {1'b0, b_hi} - {{W{1'b0}}, diff_lo[W]};
    ltu_full = diff_hi[W];
    ovf      = (diff_hi[W-1] ^ a_hi[W-1]) & (a_hi[W-1] ^ b_hi[W-1]);
    lt_full  = diff_hi[W-1] ^ ovf;
    eq_full  = ~|((a_lo ^ b_lo) | (a_hi ^ b_hi));
    if (b_zero) begin
      eq  = ~|(a_lo | a_hi);
      lt  = a_hi[W-1];
      ltu = 1'b0;
    end else begin
      eq  = eq_full;
      lt  = lt_full;
      ltu = ltu_full;
    end
  end
endmodule

// File: rtl/bru_decide.sv
// Selects the requested condition from the compare flags.
module bru_decide
  import bru_pkg::*;
(
  input  bru_op_e op,
  input  logic    eq,
  input  logic    lt,
  input  logic    ltu,
  output logic    take_req,
  output logic    is_jump
);
  always_comb begin
    is_jump = 1'b0;
    unique case (op)
      BR_EQ:   take_req = eq;
      BR_NE:   take_req = ~eq;
      BR_LT:   take_req = lt;
      BR_GE:   take_req = ~lt;
      BR_LTU:  take_req = ltu;
      BR_GEU:  take_req = ~ltu;
      default: begin
        take_req = 1'b1;
        is_jump  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bru_target.sv
// Target, sequential address and alignment fault detection.
module bru_target
  import bru_pkg::*;
#(
  parameter int W = 64
) (
  input  bru_op_e      op,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] base,
  input  logic         short_insn,
  input  logic         rvc_en,
  output logic [W-1:0] target,
  output logic [W-1:0] seq_pc,
  output logic         bad_align
);
  localparam logic [W-1:0] LEN_SHORT = W'(2);
  localparam logic [W-1:0] LEN_FULL  = W'(4);

  logic [W-1:0] ind_sum;

  always_comb begin
    ind_sum = base + imm;
    if (op == JMP_IND) target = {ind_sum[W-1:1], 1'b0};
    else               target = pc + imm;
    seq_pc = pc + (short_insn ? LEN_SHORT : LEN_FULL);
    if (rvc_en)              bad_align = 1'b0;
    else if (op == JMP_IND)  bad_align = target[1];
    else                     bad_align = |target[1:0];
  end
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter int W  = 64,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [W-1:0]  src1_lo,
  input  logic [W-1:0]  src1_hi,
  input  logic [W-1:0]  src2_lo,
  input  logic [W-1:0]  src2_hi,
  input  logic          src2_is_x0,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  imm,
  input  logic          short_insn,
  input  logic          rvc_en,
  input  logic [RW-1:0] rd,
  output logic          out_valid,
  output logic          taken,
  output logic [W-1:0]  next_pc,
  output logic          link_we,
  output logic [RW-1:0] link_rd,
  output logic [W-1:0]  link_val,
  output logic          misaligned
);
  bru_op_e      op_e;
  logic         eq, lt, ltu, take_req, is_jump, bad_align, fault;
  logic [W-1:0] target, seq_pc;
  bru_op_e      op_q;
  logic         rvc_q;

  assign op_e  = bru_op_e'(op);
  assign fault = take_req & bad_align;

  bru_cmp #(.W(W)) u_cmp (
    .a_lo(src1_lo), .a_hi(src1_hi), .b_lo(src2_lo), .b_hi(src2_hi),
    .b_zero(src2_is_x0), .eq(eq), .lt(lt), .ltu(ltu)
  );

  bru_decide u_dec (
    .op(op_e), .eq(eq), .lt(lt), .ltu(ltu),
    .take_req(take_req), .is_jump(is_jump)
  );

  bru_target #(.W(W)) u_tgt (
    .op(op_e), .pc(pc), .imm(imm), .base(src1_lo), .short_insn(short_insn),
    .rvc_en(rvc_en), .target(target), .seq_pc(seq_pc), .bad_align(bad_align)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      link_we    <= 1'b0;
      misaligned <= 1'b0;
      next_pc    <= '0;
      link_val   <= '0;
      link_rd    <= '0;
      op_q       <= BR_EQ;
      rvc_q      <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      taken      <= in_valid & take_req & ~fault;
      misaligned <= in_valid & fault;
      link_we    <= in_valid & is_jump & (rd != '0) & ~fault;
      next_pc    <= take_req ? target : seq_pc;
      link_val   <= seq_pc;
      link_rd    <= rd;
      op_q       <= op_e;
      rvc_q      <= rvc_en;
    end
  end

  // R10: a result follows each request by one cycle
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10: quiet outputs when no request was made
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !taken && !link_we && !misaligned));
  // R6: a faulting target neither redirects nor links
  a_r6_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (!taken && !link_we));
  // R6: without compressed support every redirect lands on a 4-byte boundary
  a_r6_aligned_redirect: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken && !rvc_q) |-> (next_pc[1:0] == 2'b00));
  // R7: indirect targets are always even
  a_r7_even_target: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken && op_q == JMP_IND) |-> !next_pc[0]);
  // R9: the zero register is never written
  a_r9_no_x0_write: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_rd != '0));
  // R9: conditional branches never link
  a_r9_branch_no_link: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q != JMP_DIR && op_q != JMP_IND) |-> !link_we);
endmodule

// File: tb/bru_resolve_test.sv
`timescale 1ns/1ps
module bru_resolve_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [63:0] src1_lo, src1_hi, src2_lo, src2_hi, pc, imm;
  logic        src2_is_x0, short_insn, rvc_en;
  logic [4:0]  rd;
  logic        out_valid, taken, link_we, misaligned;
  logic [63:0] next_pc, link_val;
  logic [4:0]  link_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values for the request in flight
  logic        e_taken, e_mis, e_lwe;
  logic [63:0] e_next, e_link;
  logic [4:0]  e_rd;
  string       t_cond, t_mis;

  always #2.5 clk = ~clk;

  bru_resolve uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src1_lo(src1_lo), .src1_hi(src1_hi), .src2_lo(src2_lo), .src2_hi(src2_hi),
    .src2_is_x0(src2_is_x0), .pc(pc), .imm(imm), .short_insn(short_insn),
    .rvc_en(rvc_en), .rd(rd), .out_valid(out_valid), .taken(taken),
    .next_pc(next_pc), .link_we(link_we), .link_rd(link_rd),
    .link_val(link_val), .misaligned(misaligned)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one request
  task automatic model();
    logic [127:0] a, b;
    logic         c, m;
    logic [63:0]  tgt, seq;
    a = {src1_hi, src1_lo};
    b = src2_is_x0 ? 128'd0 : {src2_hi, src2_lo};
    case (op)
      3'd0: c = (a == b);
      3'd1: c = (a != b);
      3'd2: c = ($signed(a) <  $signed(b));
      3'd3: c = ($signed(a) >= $signed(b));
      3'd4: c = (a <  b);
      3'd5: c = (a >= b);
      default: c = 1'b1;
    endcase
    tgt = (op == 3'd7) ? ((src1_lo + imm) & ~64'd1) : (pc + imm);
    seq = pc + (short_insn ? 64'd2 : 64'd4);
    m = c && !rvc_en && ((op == 3'd7) ? tgt[1] : (tgt[1:0] != 2'b00));
    e_taken = c && !m;
    e_mis   = m;
    e_next  = c ? tgt : seq;
    e_lwe   = (op >= 3'd6) && (rd != 5'd0) && !m;
    e_link  = seq;
    e_rd    = rd;
    if (src2_is_x0 && op < 3'd6) t_cond = "R4 taken";
    else if (op < 3'd2) t_cond = "R1 taken";
    else if (op < 3'd4) t_cond = "R2 taken";
    else if (op < 3'd6) t_cond = "R3 taken";
    else if (op == 3'd6) t_cond = "R8 taken";
    else t_cond = "R7 taken";
    t_mis = (op == 3'd7) ? "R7 misaligned" : "R6 misaligned";
  endtask

  task automatic issue(input logic [2:0] o, input logic [127:0] a, input logic [127:0] b,
                       input logic bz, input logic [63:0] p, input logic [63:0] i,
                       input logic sh, input logic rvc, input logic [4:0] r);
    in_valid = 1'b1; op = o;
    {src1_hi, src1_lo} = a; {src2_hi, src2_lo} = b;
    src2_is_x0 = bz; pc = p; imm = i; short_insn = sh; rvc_en = rvc; rd = r;
    model();
    @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid", 64'(out_valid), 64'd1);
    chk(t_cond, 64'(taken), 64'(e_taken));
    chk(t_mis, 64'(misaligned), 64'(e_mis));
    chk("R5 next_pc", next_pc, e_next);
    chk("R9 link_we", 64'(link_we), 64'(e_lwe));
    chk("R9 link_val", link_val, e_link);
    if (e_lwe) chk("R9 link_rd", 64'(link_rd), 64'(e_rd));
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle out_valid", 64'(out_valid), 64'd0);
    chk("R10 idle flags", {61'd0, taken, link_we, misaligned}, 64'd0);
  endtask

  localparam logic [127:0] SMIN  = {1'b1, 127'd0};
  localparam logic [127:0] SMAX  = {1'b0, {127{1'b1}}};
  localparam logic [127:0] JUNK  = {64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3211};

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; src1_lo = '0; src1_hi = '0;
    src2_lo = '0; src2_hi = '0; src2_is_x0 = 1'b0; pc = '0; imm = '0;
    short_insn = 1'b0; rvc_en = 1'b0; rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset flags", {61'd0, taken, link_we, misaligned}, 64'd0);
    rst = 1'b0;
    idle();
    // R1: equality across both halves
    issue(3'd0, {64'd5, 64'd9}, {64'd5, 64'd9}, 0, 64'h1000, 64'h40, 0, 0, 0);
    issue(3'd0, {64'd5, 64'd9}, {64'd6, 64'd9}, 0, 64'h1000, 64'h40, 0, 0, 0);
    issue(3'd1, {64'd5, 64'd9}, {64'd5, 64'd8}, 0, 64'h1000, -64'sd8, 0, 0, 0);
    issue(3'd1, JUNK, JUNK, 0, 64'h1000, 64'h40, 1, 0, 0);
    // R2: signed extremes
    issue(3'd2, SMIN, SMAX, 0, 64'h2000, 64'h10, 0, 0, 0);
    issue(3'd3, SMAX, SMIN, 0, 64'h2000, 64'h10, 0, 0, 0);
    issue(3'd2, {128{1'b1}}, 128'd1, 0, 64'h2000, 64'h10, 0, 0, 0);
    issue(3'd3, {128{1'b1}}, 128'd1, 0, 64'h2000, 64'h10, 0, 0, 0);
    // R3: unsigned, borrow from the low half
    issue(3'd4, SMIN, SMAX, 0, 64'h3000, 64'h20, 0, 0, 0);
    issue(3'd4, {64'd7, 64'd1}, {64'd7, 64'd2}, 0, 64'h3000, 64'h20, 0, 0, 0);
    issue(3'd5, {64'd7, 64'd1}, {64'd7, 64'd2}, 0, 64'h3000, 64'h20, 0, 0, 0);
    issue(3'd5, {64'd8, 64'd0}, {64'd7, {64{1'b1}}}, 0, 64'h3000, 64'h20, 0, 0, 0);
    // R4: zero register ignores src2 data
    issue(3'd0, 128'd0, JUNK, 1, 64'h4000, 64'h8, 0, 0, 0);
    issue(3'd2, SMIN, JUNK, 1, 64'h4000, 64'h8, 0, 0, 0);
    issue(3'd4, 128'd3, JUNK, 1, 64'h4000, 64'h8, 0, 0, 0);
    issue(3'd5, 128'd0, JUNK, 1, 64'h4000, 64'h8, 0, 0, 0);
    issue(3'd3, 128'd0, SMAX, 1, 64'h4000, 64'h8, 0, 0, 0);
    // R6: branch alignment with and without compressed support
    issue(3'd0, 128'd1, 128'd1, 0, 64'h1000, 64'h6, 0, 0, 0);
    issue(3'd0, 128'd1, 128'd1, 0, 64'h1000, 64'h6, 0, 1, 0);
    issue(3'd1, 128'd1, 128'd1, 0, 64'h1000, 64'h6, 1, 0, 0);
    // R8: direct jumps
    issue(3'd6, 128'd0, 128'd0, 0, 64'h5000, 64'h100, 1, 1, 5'd1);
    issue(3'd6, 128'd0, 128'd0, 0, 64'h5000, 64'h100, 0, 0, 5'd0);
    issue(3'd6, 128'd0, 128'd0, 0, 64'h5000, 64'h102, 0, 0, 5'd3);
    // R7: indirect jumps
    issue(3'd7, 128'h2001, 128'd0, 0, 64'h6000, 64'h0, 0, 0, 5'd1);
    issue(3'd7, 128'h2002, 128'd0, 0, 64'h6000, 64'h0, 0, 0, 5'd1);
    issue(3'd7, 128'h2002, 128'd0, 0, 64'h6000, 64'h1, 0, 0, 5'd1);
    issue(3'd7, 128'h2000, 128'd0, 0, 64'h6000, 64'h3, 1, 1, 5'd31);
    idle();
    // mixed random requests, back to back with occasional gaps
    for (int n = 0; n < 400; n++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (n % 4 == 0) rb[127:64] = ra[127:64];
      if (n % 8 == 1) rb = ra;
      issue(3'($urandom), ra, rb, ($urandom % 5) == 0, {$urandom, $urandom},
            {{32{1'b0}}, $urandom} - 64'h8000_0000, 1'($urandom), 1'($urandom),
            5'($urandom));
      if (n % 17 == 0) idle();
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule